// File: doc/BRIEF.md
# Stereo Serial DAC Clock and Data Generator

This block drives a stereo audio DAC that takes 16-bit samples over a three-clock serial link. From a single core clock it derives a master clock at 128 times the sample rate, a bit clock at 32 times the sample rate and a channel-select (word) clock at the sample rate. All three come from one free-running phase counter, so they stay phase-coherent and their periods never vary. The core clock runs at twice the master clock rate. At the nominal 8 kHz sample rate that means a 2.048 MHz core clock, a 1.024 MHz master clock and a 256 kHz bit clock.

Each frame is 256 core cycles long and holds 32 bit slots. The left word goes out in the first 16 slots with the word clock high. The right word follows in the next 16 slots with the word clock low. Each word is sent most significant bit first. The first bit of each word shares its slot with the word-clock edge, so the data is left-justified.

Upstream logic delivers one left/right pair at a time through a valid/ready handshake into a one-entry holding register. The pair is moved into the frame shifter only at a frame boundary. If no pair is waiting at a boundary, the previous pair is sent again and a one-cycle underflow pulse is raised.

Top module: `dacser_top`

## Requirements
- R1: `dac_sysclk` toggles on every core cycle once reset is released, so its period is exactly 2 core cycles with no stretched or shortened pulse.
- R2: `dac_bclk` has a period of 8 core cycles: it is low for the first 4 core cycles of each bit slot and high for the last 4. Its edges fall in cycles where `dac_sysclk` is low.
- R3: A frame is 256 core cycles. `dac_ws` is high for bit slots 0 to 15 (left) and low for slots 16 to 31 (right), and it changes level only together with a falling edge of `dac_bclk`.
- R4: `dac_sdata` in slot s of a frame carries bit (31 - s) of the 32-bit value {left, right}. The data is therefore MSB first and left before right, and the first bit of each word sits in the same slot as the `dac_ws` edge.
- R5: `dac_sdata` changes only at the start of a bit slot, while `dac_bclk` is low. It is stable while `dac_bclk` is high.
- R6: `in_ready` is high exactly when the holding register is empty. A pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The accepted pair is transmitted starting with the first frame that begins after the acceptance. A pair accepted on the boundary edge itself waits for the following frame.
- R7: If the holding register is empty at a frame boundary, the new frame repeats the previous pair. In that case `underflow` is high for exactly one core cycle, the first cycle of the new frame.
- R8: While `rst` is high, `dac_sysclk`, `dac_bclk`, `dac_ws`, `dac_sdata` and `underflow` are low, `in_ready` is high, and the holding register is emptied. The first core cycle after release starts a left slot, and that first frame sends the all-zero pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master clock rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream pair is valid |
| in_ready | output | 1 | Holding register can accept a pair |
| in_left | input | 16 | Left-channel sample |
| in_right | input | 16 | Right-channel sample |
| dac_sysclk | output | 1 | Master clock, 128 x sample rate |
| dac_bclk | output | 1 | Bit clock, 32 x sample rate |
| dac_ws | output | 1 | Word clock, high for the left channel |
| dac_sdata | output | 1 | Serial data, MSB first |
| underflow | output | 1 | One-cycle pulse when a pair is repeated |

## Verification
Every DAC-side output is registered once behind the phase counter. The clock, word and data levels for phase p therefore appear one core cycle after the edge that leaves phase p. The underflow pulse shows up in that same cycle after the boundary edge, and `in_ready` falls in the cycle right after an accepting edge. The bench model advances on each rising edge using these latencies: it pops its queue at the boundary before it pushes any pair accepted on that edge. All outputs are compared at the following falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

    localparam int unsigned WORD_W       = 16;
    localparam int unsigned SYS_PER_BIT  = 4;
    localparam int unsigned CORE_PER_SYS = 2;
    localparam int unsigned FRAME_BITS   = 2 * WORD_W;
    localparam int unsigned CORE_PER_BIT = SYS_PER_BIT * CORE_PER_SYS;
    localparam int unsigned BIT_LSB      = $clog2(CORE_PER_BIT);
    localparam int unsigned PH_W         = BIT_LSB + $clog2(FRAME_BITS);
    localparam int unsigned SYS_IDX      = $clog2(CORE_PER_SYS) - 1;
    localparam int unsigned BCLK_IDX     = BIT_LSB - 1;

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    typedef struct packed {
        logic sysclk;
        logic bclk;
        logic ws;
    } clks_t;

    function automatic clks_t clocks_at(phase_t ph);
        clks_t c;
        c.sysclk = ph[SYS_IDX];
        c.bclk   = ph[BCLK_IDX];
        c.ws     = ~ph[PH_W-1];
        return c;
    endfunction

    function automatic logic slot_last(phase_t ph);
        return &ph[BIT_LSB-1:0];
    endfunction

    function automatic logic frame_last(phase_t ph);
        return &ph;
    endfunction

endpackage

// File: rtl/dacser_timebase.sv
module dacser_timebase
    import dacser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   run_q,
    output clks_t  clk_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            run_q <= 1'b0;
            clk_q <= '0;
        end else begin
            phase <= phase + 1'b1;
            run_q <= 1'b1;
            clk_q <= clocks_at(phase);
        end
    end

    AST_SYSCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        run_q |=> (clk_q.sysclk != $past(clk_q.sysclk))); // R1

    AST_WS_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (rst)
        (($rose(clk_q.ws) || $fell(clk_q.ws)) && $past(run_q)) |-> $fell(clk_q.bclk)); // R3

endmodule

// File: rtl/dacser_holdbuf.sv
module dacser_holdbuf
    import dacser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  pair_t in_pair,
    output logic  in_ready,
    input  logic  take,
    output pair_t hold,
    output logic  full,
    output logic  underflow
);

    assign in_ready = ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            full      <= 1'b0;
            underflow <= 1'b0;
        end else begin
            underflow <= take & ~full;
            if (take && full) begin
                full <= 1'b0;
            end else if (in_valid && !full) begin
                hold <= in_pair;
                full <= 1'b1;
            end
        end
    end

    AST_UF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        underflow |=> !underflow); // R7

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(hold))); // R6

endmodule

// File: rtl/dacser_shifter.sv
module dacser_shifter
    import dacser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  logic   load,
    input  pair_t  load_pair,
    output logic   sdata
);

    localparam int unsigned SR_MSB = FRAME_BITS - 1;

    logic [SR_MSB:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            sdata <= 1'b0;
        end else begin
            sdata <= sr[SR_MSB];
            if (load) begin
                sr <= load_pair;
            end else if (slot_last(phase)) begin
                sr <= {sr[SR_MSB-1:0], sr[SR_MSB]};
            end
        end
    end

endmodule

// File: rtl/dacser_top.sv
module dacser_top
    import dacser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    output logic              dac_sysclk,
    output logic              dac_bclk,
    output logic              dac_ws,
    output logic              dac_sdata,
    output logic              underflow
);

    phase_t phase;
    logic   run_q;
    clks_t  clk_q;
    pair_t  in_pair;
    pair_t  hold;
    logic   full;
    logic   boundary;

    assign in_pair.left  = in_left;
    assign in_pair.right = in_right;
    assign boundary      = frame_last(phase);

    dacser_timebase u_tb (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .run_q (run_q),
        .clk_q (clk_q)
    );

    dacser_holdbuf u_hb (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pair   (in_pair),
        .in_ready  (in_ready),
        .take      (boundary),
        .hold      (hold),
        .full      (full),
        .underflow (underflow)
    );

    dacser_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .load      (boundary & full),
        .load_pair (hold),
        .sdata     (dac_sdata)
    );

    assign dac_sysclk = clk_q.sysclk;
    assign dac_bclk   = clk_q.bclk;
    assign dac_ws     = clk_q.ws;

    AST_SDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        dac_bclk |-> $stable(dac_sdata)); // R5

    AST_BCLK_RISE_SYS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_bclk) |-> !dac_sysclk); // R2

    AST_BCLK_FALL_SYS_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_bclk) |-> !dac_sysclk); // R2

endmodule

// File: tb/sim_dacser_top.sv
module sim_dacser_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0;
    logic [15:0] in_right = '0;
    logic        in_ready;
    logic        dac_sysclk, dac_bclk, dac_ws, dac_sdata, underflow;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    dacser_top u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_left    (in_left),
        .in_right   (in_right),
        .dac_sysclk (dac_sysclk),
        .dac_bclk   (dac_bclk),
        .dac_ws     (dac_ws),
        .dac_sdata  (dac_sdata),
        .underflow  (underflow)
    );

    // Behavioural reference: phase integer, pair queue of depth one.
    int          ph = 0;
    logic [31:0] cur = '0;
    logic [31:0] q[$];
    logic e_sck = 0, e_bclk = 0, e_ws = 0, e_sd = 0, e_uf = 0, e_rdy = 1;
    bit   e_rst = 1;

    always @(posedge clk) begin
        int pre;
        int slot;
        pre = q.size();
        if (rst) begin
            ph = 0; cur = '0; q.delete();
            e_sck = 0; e_bclk = 0; e_ws = 0; e_sd = 0; e_uf = 0;
            e_rst = 1;
        end else begin
            e_rst  = 0;
            slot   = ph / 8;
            e_sck  = (ph % 2) == 1;
            e_bclk = (ph % 8) >= 4;
            e_ws   = slot < 16;
            e_sd   = cur[31 - slot];
            e_uf   = 0;
            if (ph == 255) begin
                if (pre > 0) cur = q.pop_front();
                else e_uf = 1;
            end
            if (in_valid && pre == 0) q.push_back({in_left, in_right});
            ph = (ph + 1) % 256;
        end
        e_rdy = (q.size() == 0);
    end

    task automatic cmp1(input logic act, input logic exp, input string tag);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (e_rst) begin
                cmp1(dac_sysclk, 1'b0, "R8 sysclk in reset");
                cmp1(dac_bclk,   1'b0, "R8 bclk in reset");
                cmp1(dac_ws,     1'b0, "R8 ws in reset");
                cmp1(dac_sdata,  1'b0, "R8 sdata in reset");
                cmp1(underflow,  1'b0, "R8 underflow in reset");
                cmp1(in_ready,   1'b1, "R8 ready in reset");
            end else begin
                cmp1(dac_sysclk, e_sck,  "R1 sysclk");
                cmp1(dac_bclk,   e_bclk, "R2 bclk");
                cmp1(dac_ws,     e_ws,   "R3 ws");
                cmp1(dac_sdata,  e_sd,   e_bclk ? "R5 sdata" : "R4 sdata");
                cmp1(underflow,  e_uf,   "R7 underflow");
                cmp1(in_ready,   e_rdy,  "R6 ready");
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R1 watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic send(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        // R8: first frame carries zeros; R4, R6: back-to-back pairs
        send(16'hFFFF, 16'h0000);
        send(16'h0000, 16'hFFFF);
        send(16'h8001, 16'h7FFE);
        send(16'hA5A5, 16'h5A5A);
        for (int i = 0; i < 4; i++)
            send(16'h1357 * (i + 3), 16'hC0DE ^ (16'h0F0F * i));
        // R7: starve for three frames, previous pair repeats
        idle(800);
        // R6: sparse arrivals at varied phases
        for (int i = 0; i < 6; i++) begin
            idle(37 * i + 90);
            send(16'h2468 + 16'(i), 16'hFEDC - 16'(i * 5));
        end
        idle(600);
        // R8: reset mid-frame, then restart
        @(negedge clk);
        in_valid = 1'b1; in_left = 16'h1111; in_right = 16'h2222;
        rst = 1'b1;
        idle(4);
        in_valid = 1'b0;
        rst = 1'b0;
        idle(20);
        send(16'hDEAD, 16'hBEEF);
        send(16'h0001, 16'h8000);
        idle(900);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule